// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block times the read and write strobes of an external bus that is split into four chip-select areas. When idle, it accepts an access request that names an area and a direction. It then counts a setup interval from the start of the access to the falling edge of the strobe. Next it holds the active-low read or write strobe for an active interval. It ends the access with a one-cycle done pulse on the cycle the strobe returns high.

Each area owns a 2-bit extension code in an 8-bit configuration register. Each code value selects a pair of setup and active counts. A companion 2-bit select field per area, supplied from outside the block, decides whether the extension code is used. If the select field does not pick the extension, a fixed short default timing applies instead. The timing, the area choice and the direction are captured when the access starts. A register or select change made during an access therefore has no effect on that access.

Top module: `bus_strobe_timer`

## Requirements
- R1: After synchronous active-high reset, `cfg_rdata` is 00h, `rd_n` and `wr_n` are high, and `done` and `busy` are low.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the configuration register on the next clock edge, and `cfg_rdata` returns it. Area i uses bits [2i+1:2i].
- R3: With the area's select field at 11b and extension code 00, the strobe falls 2 cycles after the access starts and stays low for 3 cycles.
- R4: With the select field at 11b, extension code 01 gives 2 setup and 4 active cycles, and code 10 gives 3 setup and 4 active cycles.
- R5: With the select field at 11b, extension code 11 gives 4 setup and 5 active cycles.
- R6: When the area's field in `wait_sel` (bits [2i+1:2i]) is any value other than 11b, the access uses 1 setup cycle and 1 active cycle, whatever the extension code.
- R7: A read (`req_write` low) drives only `rd_n` low, and a write drives only `wr_n` low. The two strobes are never low together.
- R8: `done` is high for exactly one cycle, on the cycle the strobe is back high. `busy` is high from the start of the access through the done cycle. A request held high is accepted again on the edge that ends the idle cycle following done.
- R9: Timing is latched at the start of an access. Changes to the configuration register or to `wait_sel` during the access affect only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write data, 2 bits per area |
| cfg_rdata | output | 8 | Configuration register contents |
| wait_sel | input | 8 | Per-area wait-select fields; 11b enables extension |
| req_valid | input | 1 | Access request, taken while idle |
| req_area | input | 2 | Chip-select area of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle access completion pulse |
| busy | output | 1 | Access in progress |

## Verification
The bench builds the block with its default parameters: four areas, 2-bit fields, select code 11b and a 1+1 default timing. These values bring every extension code, both branches of the select decision, and the field position of each area within reach. They also cover the full range of access lengths, from the shortest one, where the done pulse follows the single strobe cycle at once, to the longest 4+5 access. Randomised configuration and select bytes are mixed with directed cases. The directed cases change the register in the middle of an access and hold a request across the done cycle.

// File: rtl/bst_pkg.sv
package bst_pkg;

   localparam int TIM_W = 4;

   typedef logic [TIM_W-1:0] tcount_t;

   typedef struct packed {
      tcount_t setup;
      tcount_t active;
   } strobe_timing_t;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_STROBE = 2'd2,
      ST_DONE   = 2'd3
   } seq_state_e;

   // Pair of counts selected by a 2-bit extension code.
   function automatic strobe_timing_t decode_ext(input logic [1:0] code);
      strobe_timing_t t;
      case (code)
         2'b00:   begin t.setup = tcount_t'(2); t.active = tcount_t'(3); end
         2'b01:   begin t.setup = tcount_t'(2); t.active = tcount_t'(4); end
         2'b10:   begin t.setup = tcount_t'(3); t.active = tcount_t'(4); end
         default: begin t.setup = tcount_t'(4); t.active = tcount_t'(5); end
      endcase
      return t;
   endfunction

endpackage

// File: rtl/bst_cfg_reg.sv
module bst_cfg_reg #(
   parameter int NUM_AREAS = 4,
   parameter int FIELD_W   = 2,
   localparam int CFG_W    = NUM_AREAS * FIELD_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] fields
);

   initial begin
      assert (NUM_AREAS >= 1) else $error("bst_cfg_reg: NUM_AREAS must be at least 1");
      assert (FIELD_W >= 1)   else $error("bst_cfg_reg: FIELD_W must be at least 1");
   end

   for (genvar i = 0; i < NUM_AREAS; i++) begin : g_field
      always_ff @(posedge clk) begin
         if (rst) begin
            fields[i*FIELD_W +: FIELD_W] <= '0;
         end else if (wr_en) begin
            fields[i*FIELD_W +: FIELD_W] <= wr_data[i*FIELD_W +: FIELD_W];
         end
      end
   end

   assert_cfg_capture_R2: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (fields == $past(wr_data)));

endmodule

// File: rtl/bst_timing_sel.sv
module bst_timing_sel
   import bst_pkg::*;
#(
   parameter int NUM_AREAS                 = 4,
   parameter int FIELD_W                   = 2,
   parameter logic [FIELD_W-1:0] EXT_CODE  = '1,
   parameter int DEF_SETUP                 = 1,
   parameter int DEF_ACTIVE                = 1,
   localparam int CFG_W                    = NUM_AREAS * FIELD_W,
   localparam int AREA_W                   = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
   input  logic [CFG_W-1:0]  ext_fields,
   input  logic [CFG_W-1:0]  sel_fields,
   input  logic [AREA_W-1:0] area,
   output strobe_timing_t    tim
);

   localparam strobe_timing_t DEF_TIM = '{setup: tcount_t'(DEF_SETUP), active: tcount_t'(DEF_ACTIVE)};

   initial begin
      assert (FIELD_W == 2) else $error("bst_timing_sel: extension decode needs 2-bit fields");
      assert (DEF_SETUP >= 1 && DEF_SETUP < (1 << TIM_W))
         else $error("bst_timing_sel: DEF_SETUP out of range");
      assert (DEF_ACTIVE >= 1 && DEF_ACTIVE < (1 << TIM_W))
         else $error("bst_timing_sel: DEF_ACTIVE out of range");
   end

   strobe_timing_t area_tim [NUM_AREAS];

   for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
      assign area_tim[i] = (sel_fields[i*FIELD_W +: FIELD_W] == EXT_CODE)
                           ? decode_ext(ext_fields[i*FIELD_W +: 2])
                           : DEF_TIM;
   end

   always_comb begin
      tim = DEF_TIM;
      for (int j = 0; j < NUM_AREAS; j++) begin
         if (area == AREA_W'(j)) tim = area_tim[j];
      end
   end

endmodule

// File: rtl/bst_seq.sv
module bst_seq
   import bst_pkg::*;
(
   input  logic           clk,
   input  logic           rst,
   input  logic           req_valid,
   input  logic           req_write,
   input  strobe_timing_t req_tim,
   output logic           rd_n,
   output logic           wr_n,
   output logic           done,
   output logic           busy
);

   seq_state_e     state;
   tcount_t        cnt;
   strobe_timing_t lat_tim;
   logic           lat_wr;
   logic           accept;

   assign accept = (state == ST_IDLE) && req_valid;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         lat_tim <= '0;
         lat_wr  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state   <= ST_SETUP;
                  cnt     <= req_tim.setup - tcount_t'(1);
                  lat_tim <= req_tim;
                  lat_wr  <= req_write;
               end
            end
            ST_SETUP: begin
               if (cnt == '0) begin
                  state <= ST_STROBE;
                  cnt   <= lat_tim.active - tcount_t'(1);
               end else begin
                  cnt <= cnt - tcount_t'(1);
               end
            end
            ST_STROBE: begin
               if (cnt == '0) state <= ST_DONE;
               else           cnt   <= cnt - tcount_t'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign rd_n = !((state == ST_STROBE) && !lat_wr);
   assign wr_n = !((state == ST_STROBE) &&  lat_wr);
   assign done = (state == ST_DONE);
   assign busy = (state != ST_IDLE);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (rd_n && wr_n && !done));

   assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      !(!rd_n && !wr_n));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_done_strobe_high_R8: assert property (@(posedge clk) disable iff (rst)
      done |-> (rd_n && wr_n && busy));

   // R3: every setup interval is at least one cycle long
   assert_setup_first_R3: assert property (@(posedge clk) disable iff (rst)
      accept |=> (rd_n && wr_n && !done && busy));

   assert_hold_timing_R9: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> ($stable(lat_tim) && $stable(lat_wr)));

endmodule

// File: rtl/bus_strobe_timer.sv
module bus_strobe_timer
   import bst_pkg::*;
#(
   parameter int NUM_AREAS                     = 4,
   parameter int FIELD_W                       = 2,
   parameter logic [FIELD_W-1:0] EXT_SEL_CODE  = '1,
   parameter int DEF_SETUP                     = 1,
   parameter int DEF_ACTIVE                    = 1,
   localparam int CFG_W                        = NUM_AREAS * FIELD_W,
   localparam int AREA_W                       = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic [CFG_W-1:0]  wait_sel,
   input  logic              req_valid,
   input  logic [AREA_W-1:0] req_area,
   input  logic              req_write,
   output logic              rd_n,
   output logic              wr_n,
   output logic              done,
   output logic              busy
);

   logic [CFG_W-1:0] ext_fields;
   strobe_timing_t   req_tim;

   bst_cfg_reg #(
      .NUM_AREAS (NUM_AREAS),
      .FIELD_W   (FIELD_W)
   ) i_cfg (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .fields  (ext_fields)
   );

   assign cfg_rdata = ext_fields;

   bst_timing_sel #(
      .NUM_AREAS  (NUM_AREAS),
      .FIELD_W    (FIELD_W),
      .EXT_CODE   (EXT_SEL_CODE),
      .DEF_SETUP  (DEF_SETUP),
      .DEF_ACTIVE (DEF_ACTIVE)
   ) i_tsel (
      .ext_fields (ext_fields),
      .sel_fields (wait_sel),
      .area       (req_area),
      .tim        (req_tim)
   );

   bst_seq i_seq (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_tim   (req_tim),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .done      (done),
      .busy      (busy)
   );

endmodule

// File: tb/test_bus_strobe_timer.sv
module test_bus_strobe_timer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic [7:0] wait_sel = '0;
   logic       req_valid = 1'b0;
   logic [1:0] req_area = '0;
   logic       req_write = 1'b0;
   logic       rd_n, wr_n, done, busy;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   bus_strobe_timer i_bus_strobe_timer (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .wait_sel  (wait_sel),
      .req_valid (req_valid),
      .req_area  (req_area),
      .req_write (req_write),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .done      (done),
      .busy      (busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_setup(input logic [7:0] c, input logic [7:0] s, input int a);
      if (s[2*a +: 2] != 2'b11) return 1;
      case (c[2*a +: 2])
         2'b00: return 2;
         2'b01: return 2;
         2'b10: return 3;
         default: return 4;
      endcase
   endfunction

   function automatic int exp_active(input logic [7:0] c, input logic [7:0] s, input int a);
      if (s[2*a +: 2] != 2'b11) return 1;
      case (c[2*a +: 2])
         2'b00: return 3;
         2'b01: return 4;
         2'b10: return 4;
         default: return 5;
      endcase
   endfunction

   function automatic string req_tag(input logic [7:0] c, input logic [7:0] s, input int a);
      if (s[2*a +: 2] != 2'b11) return "R6";
      case (c[2*a +: 2])
         2'b00: return "R3";
         2'b11: return "R5";
         default: return "R4";
      endcase
   endfunction

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      check(cfg_rdata == v, "R2", "config readback", cfg_rdata, v);
   endtask

   // Runs one access; optionally changes config and select in the middle.
   task automatic do_access(input int area, input bit wr, input int es, input int ea,
                            input string rq, input bit mutate,
                            input logic [7:0] new_cfg, input logic [7:0] new_sel);
      int first_low = -1;
      int lows = 0;
      int other_lows = 0;
      int done_cnt = 0;
      int done_k = -1;
      int last_busy = 1;
      @(negedge clk);
      req_valid = 1'b1;
      req_area  = 2'(area);
      req_write = wr;
      @(posedge clk);
      for (int k = 0; k <= es + ea + 1; k++) begin
         @(negedge clk);
         if (k == 0) begin
            req_valid = 1'b0;
            if (mutate) begin
               cfg_we = 1'b1;
               cfg_wdata = new_cfg;
               wait_sel = new_sel;
            end
         end
         if (k == 1) cfg_we = 1'b0;
         if ((wr ? wr_n : rd_n) == 1'b0) begin
            lows++;
            if (first_low < 0) first_low = k;
         end
         if ((wr ? rd_n : wr_n) == 1'b0) other_lows++;
         if (done) begin
            done_cnt++;
            done_k = k;
         end
         if (k == es + ea + 1) last_busy = busy;
      end
      check(first_low == es, rq, "setup cycles", first_low, es);
      check(lows == ea, rq, "active cycles", lows, ea);
      check(other_lows == 0, "R7", "wrong strobe low cycles", other_lows, 0);
      check(done_cnt == 1, "R8", "done pulse count", done_cnt, 1);
      check(done_k == es + ea, "R8", "done cycle", done_k, es + ea);
      check(last_busy == 0, "R8", "busy after done", last_busy, 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: run hung, actual=1 expected=0");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] c;
      logic [7:0] s;
      int a;
      bit w;
      int falls;
      int fall_k1, fall_k2, dn1, dn2;
      logic prev_rd;
      void'($urandom(32'h5eed1234));

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      check(cfg_rdata == 8'h00, "R1", "config after reset", cfg_rdata, 0);
      check(rd_n == 1'b1, "R1", "rd_n after reset", rd_n, 1);
      check(wr_n == 1'b1, "R1", "wr_n after reset", wr_n, 1);
      check(done == 1'b0, "R1", "done after reset", done, 0);
      check(busy == 1'b0, "R1", "busy after reset", busy, 0);

      // Reset config with select off: default timing (R6)
      do_access(0, 0, 1, 1, "R6", 0, 8'h00, 8'h00);

      // Each area carries a different code (R2 field positions, R3 R4 R5)
      write_cfg(8'b11_10_01_00);
      wait_sel = 8'hFF;
      do_access(0, 0, 2, 3, "R3", 0, 8'h00, 8'h00);
      do_access(1, 1, 2, 4, "R4", 0, 8'h00, 8'h00);
      do_access(2, 0, 3, 4, "R4", 0, 8'h00, 8'h00);
      do_access(3, 1, 4, 5, "R5", 0, 8'h00, 8'h00);

      // Select field not 11b overrides the code (R6)
      wait_sel = 8'b11_00_11_01;
      do_access(0, 1, 1, 1, "R6", 0, 8'h00, 8'h00);
      do_access(1, 0, 2, 4, "R4", 0, 8'h00, 8'h00);
      do_access(2, 1, 1, 1, "R6", 0, 8'h00, 8'h00);
      do_access(3, 0, 4, 5, "R5", 0, 8'h00, 8'h00);

      // R9: change config during an access, then the next access sees it
      write_cfg(8'h00);
      wait_sel = 8'hFF;
      do_access(0, 0, 2, 3, "R9", 1, 8'hFF, 8'hFF);
      check(cfg_rdata == 8'hFF, "R2", "config written mid-access", cfg_rdata, 8'hFF);
      do_access(0, 0, 4, 5, "R9", 0, 8'h00, 8'h00);
      // R9: drop select during an access
      do_access(1, 1, 4, 5, "R9", 1, 8'hFF, 8'h00);
      do_access(1, 1, 1, 1, "R9", 0, 8'h00, 8'h00);

      // R8: request held across done, area 0 code 00 (2+3)
      write_cfg(8'h00);
      wait_sel = 8'hFF;
      falls = 0; fall_k1 = -1; fall_k2 = -1; dn1 = -1; dn2 = -1;
      prev_rd = 1'b1;
      @(negedge clk);
      req_valid = 1'b1;
      req_area = 2'd0;
      req_write = 1'b0;
      @(posedge clk);
      for (int k = 0; k <= 14; k++) begin
         @(negedge clk);
         if (k == 12) req_valid = 1'b0;
         if (prev_rd && !rd_n) begin
            falls++;
            if (falls == 1) fall_k1 = k; else fall_k2 = k;
         end
         prev_rd = rd_n;
         if (done) begin
            if (dn1 < 0) dn1 = k; else dn2 = k;
         end
      end
      check(falls == 2, "R8", "held request strobe count", falls, 2);
      check(fall_k1 == 2, "R8", "first strobe fall", fall_k1, 2);
      check(fall_k2 == 9, "R8", "second strobe fall", fall_k2, 9);
      check(dn1 == 5, "R8", "first done", dn1, 5);
      check(dn2 == 12, "R8", "second done", dn2, 12);
      check(busy == 1'b0, "R8", "idle after held requests", busy, 0);

      // Constrained random accesses
      for (int n = 0; n < 40; n++) begin
         c = 8'($urandom);
         s = ($urandom % 2 == 0) ? 8'hFF : 8'($urandom);
         a = int'($urandom % 4);
         w = 1'($urandom);
         write_cfg(c);
         wait_sel = s;
         do_access(a, w, exp_setup(c, s, a), exp_active(c, s, a),
                   req_tag(c, s, a), 0, 8'h00, 8'h00);
      end

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule